// File: doc/BRIEF.md
# Trap Return Sequencer

This block carries out the two trap-return operations of a processor core: the return from a machine-level handler and the return from a supervisor-level handler. The caller raises a request with a flag that selects the returning level. With it come the privilege the hart runs at now, the saved exception PCs of both levels, the interrupt-stack fields of the status register, and a flag that says whether compressed (16-bit) instructions are supported.

One cycle after an accepted request the block raises a single-cycle done pulse. Alongside the pulse it presents one of two results. The first is the return PC, the privilege level to enter and the rewritten status fields. The second is an exception flag with its cause code, in which case every state output keeps its old value.

The privilege encoding used throughout is 0 = user, 1 = supervisor, 2 = hypervisor (reserved), 3 = machine. The status fields travel as individual bits: MIE, MPIE, the 2-bit MPP, SIE, SPIE and SPP.

The controller has two states. IDLE waits for a request. The transition IDLE to RESP is taken when a request is seen in IDLE; the result is registered on that edge. RESP asserts the done pulse. The transition RESP to IDLE is unconditional, and a request seen during RESP is dropped.

Top module: `trs_seq`

## Requirements
- R1: After reset `ret_done` = 0, `ret_exc` = 0, `ret_pc` = 0 and `nxt_priv` = 3 (machine).
- R2: A machine return (`ret_is_mach` = 1) with `cur_priv` below 3, or a supervisor return (`ret_is_mach` = 0) with `cur_priv` = 0, raises `ret_exc` with `ret_cause` = 2 (illegal instruction). This check takes precedence over R3.
- R3: When `cmp_en` = 0 and bits 1:0 of the selected return PC are not both zero, the return raises `ret_exc` with `ret_cause` = 0 (misaligned fetch address). When `cmp_en` = 1 such a PC is accepted.
- R4: A successful machine return sets MIE to the old MPIE, clears MPIE, sets MPP to 0, enters the privilege held in the old MPP, and leaves SIE, SPIE and SPP unchanged.
- R5: A successful supervisor return sets SIE to the old SPIE, clears SPIE, sets SPP to 0, enters the privilege given by the old SPP (0 or 1), and leaves MIE, MPIE and MPP unchanged.
- R6: A popped privilege of 2 (hypervisor) is replaced by 0 (user), so a successful return never enters level 2.
- R7: `ret_pc` equals `mach_epc` on a successful machine return and `sup_epc` on a successful supervisor return; the other saved PC has no effect.
- R8: When an exception is raised, `nxt_priv` equals the request's `cur_priv`, every status output equals its input, and `ret_pc` = 0.
- R9: `ret_done` is high exactly in the cycle after the edge that accepts a request, for one cycle. All result outputs are registered on that edge and hold until the next accepted request.
- R10: A request present in the cycle where `ret_done` is high is ignored: it yields no done pulse and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_req | input | 1 | Trap-return request |
| ret_is_mach | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| mach_epc | input | XLEN | Saved exception PC of machine level |
| sup_epc | input | XLEN | Saved exception PC of supervisor level |
| cmp_en | input | 1 | Compressed instructions supported |
| st_mie | input | 1 | Status MIE |
| st_mpie | input | 1 | Status MPIE |
| st_mpp | input | 2 | Status MPP |
| st_sie | input | 1 | Status SIE |
| st_spie | input | 1 | Status SPIE |
| st_spp | input | 1 | Status SPP |
| ret_done | output | 1 | Result valid pulse |
| ret_exc | output | 1 | Return raised an exception |
| ret_cause | output | CAUSE_W | Exception cause code |
| ret_pc | output | XLEN | PC to resume at |
| nxt_priv | output | 2 | Privilege level to enter |
| nx_mie | output | 1 | New MIE |
| nx_mpie | output | 1 | New MPIE |
| nx_mpp | output | 2 | New MPP |
| nx_sie | output | 1 | New SIE |
| nx_spie | output | 1 | New SPIE |
| nx_spp | output | 1 | New SPP |

## Verification
The bench targets several corner cases:
- A machine return whose saved MPP holds the reserved value 2. A design that skips the replacement would hand back privilege 2.
- A return from too low a privilege while the saved PC is also misaligned. A design with the wrong check order would report cause 0 instead of 2.
- Misaligned PCs with bit 0 set and with bit 1 set, both with compressed support and without it. These catch a check that looks at only one bit or ignores the enable.
- Each saved-PC input fed a distinct decoy value on returns of the other level. A crossed multiplexer would return the decoy.
- A request held high through the done cycle. A controller that re-arms at once would emit a second pulse and overwrite the result.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       sie;
        logic       spie;
        logic       spp;
    } stat_t;

    localparam int ALIGN_BITS = 2;
    localparam int CAUSE_ILLEGAL  = 2;
    localparam int CAUSE_MISALIGN = 0;

    // The reserved hypervisor level is never entered; user is used instead.
    function automatic priv_e legal_priv(input priv_e p);
        return (p == PRIV_H) ? PRIV_U : p;
    endfunction

endpackage

// File: rtl/trs_guard.sv
module trs_guard
    import trs_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  logic                  is_mach,
    input  logic [1:0]            cur_priv,
    input  logic [ALIGN_BITS-1:0] epc_low,
    input  logic                  cmp_en,
    output logic                  fault,
    output logic [CAUSE_W-1:0]    cause
);

    logic priv_ok;
    logic align_bad;

    always_comb begin
        if (is_mach) priv_ok = (cur_priv == PRIV_M);
        else         priv_ok = (cur_priv != PRIV_U);
    end

    assign align_bad = !cmp_en && (|epc_low);

    // Privilege violation outranks alignment (R2 over R3).
    always_comb begin
        fault = 1'b0;
        cause = CAUSE_W'(CAUSE_MISALIGN);
        if (!priv_ok) begin
            fault = 1'b1;
            cause = CAUSE_W'(CAUSE_ILLEGAL);
        end else if (align_bad) begin
            fault = 1'b1;
            cause = CAUSE_W'(CAUSE_MISALIGN);
        end
    end

endmodule

// File: rtl/trs_pop.sv
module trs_pop
    import trs_pkg::*;
(
    input  logic  is_mach,
    input  stat_t stat_in,
    output stat_t stat_out,
    output priv_e pop_priv
);

    always_comb begin
        stat_out = stat_in;
        if (is_mach) begin
            stat_out.mie  = stat_in.mpie;
            stat_out.mpie = 1'b0;
            stat_out.mpp  = PRIV_U;
            pop_priv      = legal_priv(priv_e'(stat_in.mpp));
        end else begin
            stat_out.sie  = stat_in.spie;
            stat_out.spie = 1'b0;
            stat_out.spp  = 1'b0;
            pop_priv      = legal_priv(priv_e'({1'b0, stat_in.spp}));
        end
    end

endmodule

// File: rtl/trs_seq.sv
module trs_seq
    import trs_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ret_req,
    input  logic               ret_is_mach,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    mach_epc,
    input  logic [XLEN-1:0]    sup_epc,
    input  logic               cmp_en,
    input  logic               st_mie,
    input  logic               st_mpie,
    input  logic [1:0]         st_mpp,
    input  logic               st_sie,
    input  logic               st_spie,
    input  logic               st_spp,
    output logic               ret_done,
    output logic               ret_exc,
    output logic [CAUSE_W-1:0] ret_cause,
    output logic [XLEN-1:0]    ret_pc,
    output logic [1:0]         nxt_priv,
    output logic               nx_mie,
    output logic               nx_mpie,
    output logic [1:0]         nx_mpp,
    output logic               nx_sie,
    output logic               nx_spie,
    output logic               nx_spp
);

    state_e             state_q;
    state_e             state_d;
    stat_t              stat_in;
    stat_t              stat_pop;
    stat_t              stat_q;
    priv_e              pop_priv;
    logic [XLEN-1:0]    epc_sel;
    logic               fault;
    logic [CAUSE_W-1:0] cause;

    assign stat_in = '{mie: st_mie, mpie: st_mpie, mpp: st_mpp,
                       sie: st_sie, spie: st_spie, spp: st_spp};
    assign epc_sel = ret_is_mach ? mach_epc : sup_epc;

    trs_guard #(.CAUSE_W(CAUSE_W)) u_guard (
        .is_mach  (ret_is_mach),
        .cur_priv (cur_priv),
        .epc_low  (epc_sel[ALIGN_BITS-1:0]),
        .cmp_en   (cmp_en),
        .fault    (fault),
        .cause    (cause)
    );

    trs_pop u_pop (
        .is_mach  (ret_is_mach),
        .stat_in  (stat_in),
        .stat_out (stat_pop),
        .pop_priv (pop_priv)
    );

    // Next-state logic: IDLE -> RESP on a request, RESP -> IDLE always.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ret_req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_done  <= 1'b0;
            ret_exc   <= 1'b0;
            ret_cause <= '0;
            ret_pc    <= '0;
            nxt_priv  <= PRIV_M;
            stat_q    <= '0;
        end else begin
            ret_done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (ret_req) begin
                        ret_done  <= 1'b1;
                        ret_exc   <= fault;
                        ret_cause <= cause;
                        if (fault) begin
                            ret_pc   <= '0;
                            nxt_priv <= cur_priv;
                            stat_q   <= stat_in;
                        end else begin
                            ret_pc   <= epc_sel;
                            nxt_priv <= pop_priv;
                            stat_q   <= stat_pop;
                        end
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    assign nx_mie  = stat_q.mie;
    assign nx_mpie = stat_q.mpie;
    assign nx_mpp  = stat_q.mpp;
    assign nx_sie  = stat_q.sie;
    assign nx_spie = stat_q.spie;
    assign nx_spp  = stat_q.spp;

endmodule

// File: rtl/trs_seq_sva.sv
module trs_seq_sva #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ret_req,
    input logic               ret_is_mach,
    input logic [1:0]         cur_priv,
    input logic [XLEN-1:0]    mach_epc,
    input logic [XLEN-1:0]    sup_epc,
    input logic               cmp_en,
    input logic               st_mie,
    input logic               st_mpie,
    input logic               st_sie,
    input logic               ret_done,
    input logic               ret_exc,
    input logic [CAUSE_W-1:0] ret_cause,
    input logic [XLEN-1:0]    ret_pc,
    input logic [1:0]         nxt_priv,
    input logic               nx_mie,
    input logic               nx_mpie,
    input logic [1:0]         nx_mpp,
    input logic               nx_sie
);

    logic acc;
    logic priv_ok;
    logic lo_bad;

    assign acc     = ret_req && !ret_done;
    assign priv_ok = ret_is_mach ? (cur_priv == 2'd3) : (cur_priv != 2'd0);
    assign lo_bad  = ret_is_mach ? (mach_epc[1:0] != 2'b00) : (sup_epc[1:0] != 2'b00);

    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ret_done);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |=> !ret_done);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(ret_pc) && $stable(nxt_priv) && $stable(ret_exc)));

    a_r2_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !priv_ok) |=> (ret_exc && ret_cause == CAUSE_W'(2)));

    a_r3_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && priv_ok && !cmp_en && lo_bad) |=> (ret_exc && ret_cause == CAUSE_W'(0)));

    a_r4_mach_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ret_is_mach && priv_ok && (cmp_en || !lo_bad))
        |=> (!ret_exc && nx_mie == $past(st_mpie) && !nx_mpie && nx_mpp == 2'd0));

    a_r6_no_hyp: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_done && !ret_exc) |-> (nxt_priv != 2'd2));

    a_r8_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !priv_ok)
        |=> (nxt_priv == $past(cur_priv) && nx_mie == $past(st_mie) && nx_sie == $past(st_sie)));

endmodule

bind trs_seq trs_seq_sva #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_trs_seq_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_req     (ret_req),
    .ret_is_mach (ret_is_mach),
    .cur_priv    (cur_priv),
    .mach_epc    (mach_epc),
    .sup_epc     (sup_epc),
    .cmp_en      (cmp_en),
    .st_mie      (st_mie),
    .st_mpie     (st_mpie),
    .st_sie      (st_sie),
    .ret_done    (ret_done),
    .ret_exc     (ret_exc),
    .ret_cause   (ret_cause),
    .ret_pc      (ret_pc),
    .nxt_priv    (nxt_priv),
    .nx_mie      (nx_mie),
    .nx_mpie     (nx_mpie),
    .nx_mpp      (nx_mpp),
    .nx_sie      (nx_sie)
);

// File: tb/test_trs_seq.sv
`timescale 1ns/1ps
module test_trs_seq;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 4;

    typedef struct packed {
        logic        lvl;
        logic [1:0]  cp;
        logic [31:0] epc;
        logic [6:0]  st;    // {mie, mpie, mpp[1:0], sie, spie, spp}
        logic        cmp;
        logic        exc;
        logic [3:0]  cause;
        logic [1:0]  np;
        logic [31:0] pc;
        logic [6:0]  nst;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 32'h100, 7'b0111101, 1'b0, 1'b0, 4'd0, 2'd3, 32'h100, 7'b1000101, 4'd4}, // R4 mret to M
        '{1'b1, 2'd3, 32'h104, 7'b1001010, 1'b0, 1'b0, 4'd0, 2'd1, 32'h104, 7'b0000010, 4'd4}, // R4 mret to S
        '{1'b1, 2'd3, 32'h108, 7'b0110000, 1'b0, 1'b0, 4'd0, 2'd0, 32'h108, 7'b1000000, 4'd6}, // R6 MPP=2 -> user
        '{1'b1, 2'd3, 32'h202, 7'b1100111, 1'b1, 1'b0, 4'd0, 2'd0, 32'h202, 7'b1000111, 4'd3}, // R3 compressed ok
        '{1'b1, 2'd1, 32'h100, 7'b0111101, 1'b0, 1'b1, 4'd2, 2'd1, 32'h0,   7'b0111101, 4'd2}, // R2 mret from S
        '{1'b1, 2'd3, 32'h102, 7'b0111101, 1'b0, 1'b1, 4'd0, 2'd3, 32'h0,   7'b0111101, 4'd3}, // R3 bit1
        '{1'b1, 2'd0, 32'h102, 7'b0111101, 1'b0, 1'b1, 4'd2, 2'd0, 32'h0,   7'b0111101, 4'd2}, // R2 precedence
        '{1'b0, 2'd1, 32'h300, 7'b1011010, 1'b0, 1'b0, 4'd0, 2'd0, 32'h300, 7'b1011100, 4'd5}, // R5 sret to U
        '{1'b0, 2'd3, 32'h404, 7'b0000101, 1'b0, 1'b0, 4'd0, 2'd1, 32'h404, 7'b0000000, 4'd5}, // R5 sret from M
        '{1'b0, 2'd0, 32'h300, 7'b0000101, 1'b0, 1'b1, 4'd2, 2'd0, 32'h0,   7'b0000101, 4'd2}, // R2 sret from U
        '{1'b0, 2'd1, 32'h301, 7'b0000011, 1'b0, 1'b1, 4'd0, 2'd1, 32'h0,   7'b0000011, 4'd8}, // R8 state kept
        '{1'b0, 2'd1, 32'h301, 7'b0000011, 1'b1, 1'b0, 4'd0, 2'd1, 32'h301, 7'b0000100, 4'd7}, // R7 sup_epc used
        '{1'b1, 2'd3, 32'h101, 7'b1110000, 1'b0, 1'b1, 4'd0, 2'd3, 32'h0,   7'b1110000, 4'd3}, // R3 bit0
        '{1'b0, 2'd2, 32'h500, 7'b0000111, 1'b0, 1'b0, 4'd0, 2'd1, 32'h500, 7'b0000100, 4'd5}  // R5 sret from H
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ret_req = 1'b0;
    logic               ret_is_mach = 1'b0;
    logic [1:0]         cur_priv = 2'd0;
    logic [XLEN-1:0]    mach_epc = '0;
    logic [XLEN-1:0]    sup_epc = '0;
    logic               cmp_en = 1'b0;
    logic [6:0]         st_in = '0;
    logic               ret_done;
    logic               ret_exc;
    logic [CAUSE_W-1:0] ret_cause;
    logic [XLEN-1:0]    ret_pc;
    logic [1:0]         nxt_priv;
    logic               nx_mie, nx_mpie, nx_sie, nx_spie, nx_spp;
    logic [1:0]         nx_mpp;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trs_seq #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trs_seq (
        .clk(clk), .rst_n(rst_n), .ret_req(ret_req), .ret_is_mach(ret_is_mach),
        .cur_priv(cur_priv), .mach_epc(mach_epc), .sup_epc(sup_epc), .cmp_en(cmp_en),
        .st_mie(st_in[6]), .st_mpie(st_in[5]), .st_mpp(st_in[4:3]),
        .st_sie(st_in[2]), .st_spie(st_in[1]), .st_spp(st_in[0]),
        .ret_done(ret_done), .ret_exc(ret_exc), .ret_cause(ret_cause), .ret_pc(ret_pc),
        .nxt_priv(nxt_priv), .nx_mie(nx_mie), .nx_mpie(nx_mpie), .nx_mpp(nx_mpp),
        .nx_sie(nx_sie), .nx_spie(nx_spie), .nx_spp(nx_spp)
    );

    function automatic logic [45:0] result();
        return {ret_exc, ret_cause, nxt_priv, ret_pc,
                nx_mie, nx_mpie, nx_mpp, nx_sie, nx_spie, nx_spp};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Drives a vector; the other level's saved PC gets a decoy (R7).
    task automatic drive(input vec_t v);
        ret_is_mach = v.lvl;
        cur_priv    = v.cp;
        mach_epc    = v.lvl ? v.epc : 32'hDEAD_BEE0;
        sup_epc     = v.lvl ? 32'hCAFE_0000 : v.epc;
        cmp_en      = v.cmp;
        st_in       = v.st;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ret_done == 1'b0 && ret_exc == 1'b0 && ret_pc == '0 && nxt_priv == 2'd3,
              "R1", "reset outputs", {ret_done, ret_exc, nxt_priv, ret_pc},
              {1'b0, 1'b0, 2'd3, 32'h0});
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            drive(VECS[i]);
            ret_req = 1'b1;
            @(negedge clk);
            ret_req = 1'b0;
            check(ret_done == 1'b1, $sformatf("R%0d", VECS[i].rq), "done pulse", 64'(ret_done), 64'd1);
            check(result() == {VECS[i].exc, VECS[i].cause, VECS[i].np, VECS[i].pc, VECS[i].nst},
                  $sformatf("R%0d", VECS[i].rq), $sformatf("vector %0d result", i),
                  64'(result()),
                  64'({VECS[i].exc, VECS[i].cause, VECS[i].np, VECS[i].pc, VECS[i].nst}));
            @(negedge clk);
            // R9: pulse is one cycle wide and outputs hold
            check(ret_done == 1'b0, "R9", "done width", 64'(ret_done), 64'd0);
            check(result() == {VECS[i].exc, VECS[i].cause, VECS[i].np, VECS[i].pc, VECS[i].nst},
                  "R9", "hold after done", 64'(result()),
                  64'({VECS[i].exc, VECS[i].cause, VECS[i].np, VECS[i].pc, VECS[i].nst}));
        end

        // R10: request held through the done cycle with different inputs
        drive(VECS[0]);
        ret_req = 1'b1;
        @(negedge clk);
        check(ret_done == 1'b1 && ret_pc == 32'h100, "R10", "first accepted",
              {ret_done, ret_pc}, {1'b1, 32'h100});
        drive(VECS[8]);
        @(negedge clk);
        ret_req = 1'b0;
        check(ret_done == 1'b0, "R10", "no second pulse", 64'(ret_done), 64'd0);
        check(ret_pc == 32'h100 && nxt_priv == 2'd3, "R10", "outputs unchanged",
              {nxt_priv, ret_pc}, {2'd3, 32'h100});
        @(negedge clk);
        check(ret_done == 1'b0 && ret_pc == 32'h100, "R10", "still idle",
              {ret_done, ret_pc}, {1'b0, 32'h100});

        // R7: machine return picks mach_epc even when sup_epc is misaligned
        drive(VECS[0]);
        sup_epc = 32'h0000_0003;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        check(ret_exc == 1'b0 && ret_pc == 32'h100, "R7", "mach_epc selected",
              {ret_exc, ret_pc}, {1'b0, 32'h100});

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule